// File: doc/BRIEF.md
# Dual-Channel Serial Delay-Code Loader

This block takes a three-wire serial control stream: a data line, a shift clock and a load strobe. From it the block builds two 10-bit delay codes, one for each of two signal channels. The three serial lines are asynchronous to the block. Two flops bring each of them into the system clock domain, and the block acts on the edges of the synchronised copies.

On every rising edge of the shift clock, the data bit moves into a 20-bit scan chain. A hold register sits between the chain and the code outputs. While the load strobe is high, the hold register follows the chain; while it is low, the hold register keeps its value. The bit that leaves the far end of the chain is driven on a serial output, so that several loaders can be wired in a daisy chain.

Each code is binary weighted. The block reports the nominal total delay of each channel in picoseconds. Each channel also has a one-register data path with an active-low enable. When the enable is released, the true output is forced low and the complement output is forced high.

A two-state machine controls the hold register. The state SHIFT_ST holds the codes. The state XFER_ST copies the chain into the hold register on every cycle. The machine moves from SHIFT_ST to XFER_ST when the synchronised load is high, and from XFER_ST back to SHIFT_ST when it is low.

Top module: `dlycode_loader`

## Requirements
- R1: An active-low reset clears the scan chain, the hold register and both codes to zero. After reset both delay outputs show BASE_PS (2000), ser_dout is 0, both true outputs are 0 and both complement outputs are 1.
- R2: Each synchronised rising edge of ser_clk shifts ser_din into bit 0 of the chain, and every other bit moves up one place. After 20 shifts and a load pulse, code_b holds the first ten bits shifted, with the very first bit at code_b bit 9. code_a holds the last ten bits, with the last bit at code_a bit 0.
- R3: While ser_load is low, shifting does not change code_a or code_b.
- R4: While ser_load is high, the codes follow the chain. A shift made during that time therefore reaches the codes at once.
- R5: ser_dout shows chain bit 19. After the n-th shift it equals the bit taken at shift n-19, so a unit further down the chain receives each bit 20 shift edges later. Until 19 shifts have followed a reset, ser_dout is 0.
- R6: dly_a = BASE_PS + STEP_PS * code_a, and the same holds for channel B. The defaults are BASE_PS 2000 and STEP_PS 5, so bit n is worth 5 * 2^n ps and all ones adds 5115 ps.
- R7: When ena_n_x is high, q_x is 0 and q_n_x is 1 from the next clock on. When ena_n_x is low, q_x takes in_x one clock later and q_n_x is its inverse.
- R8: The two enables act on their own channel only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_din | input | 1 | Serial data in |
| ser_clk | input | 1 | Serial shift clock; shifts on its rising edge |
| ser_load | input | 1 | Load strobe; hold register transparent while high |
| ser_dout | output | 1 | Chain end, for the next cascaded unit |
| in_a | input | 1 | Channel A data in |
| ena_n_a | input | 1 | Channel A active-low enable |
| in_b | input | 1 | Channel B data in |
| ena_n_b | input | 1 | Channel B active-low enable |
| q_a | output | 1 | Channel A true output |
| q_n_a | output | 1 | Channel A complement output |
| q_b | output | 1 | Channel B true output |
| q_n_b | output | 1 | Channel B complement output |
| code_a | output | 10 | Channel A delay code |
| code_b | output | 10 | Channel B delay code |
| dly_a | output | 13 | Channel A nominal delay in ps |
| dly_b | output | 13 | Channel B nominal delay in ps |

## Verification
The properties assume that the serial lines change slowly compared with the system clock. Each level must last several system cycles, so that every edge survives the two-flop synchroniser and is seen exactly once. They also assume that ser_din is stable around each rising edge of ser_clk. The stimulus holds every serial level for at least six system cycles. It changes ser_din only while ser_clk is low. It toggles ser_clk during a high load only in the one test meant to show the transparent path.

// File: rtl/dlycode_pkg.sv
package dlycode_pkg;
    localparam int CODE_W  = 10;
    localparam int NCH     = 2;
    localparam int CHAIN_W = CODE_W * NCH;
    localparam int BASE_PS = 2000;
    localparam int STEP_PS = 5;
    localparam int DLY_W   = $clog2(BASE_PS + STEP_PS * ((1 << CODE_W) - 1) + 1);

    typedef enum logic [0:0] {
        SHIFT_ST = 1'b0,
        XFER_ST  = 1'b1
    } ld_state_e;
endpackage

// File: rtl/dlycode_sync.sv
module dlycode_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o,
    output logic [WIDTH-1:0] rise_o
);
    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] prev_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      stage_q[g] <= '0;
                else if (g == 0) stage_q[g] <= async_i;
                else             stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= stage_q[STAGES-1];
    end

    assign sync_o = stage_q[STAGES-1];
    assign rise_o = stage_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/dlycode_chain.sv
module dlycode_chain
    import dlycode_pkg::*;
#(
    parameter int CHAIN_W = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift_en,
    input  logic               bit_in,
    input  logic               load_lvl,
    output logic               chain_end,
    output logic [CHAIN_W-1:0] hold_o
);
    ld_state_e          state_q, state_d;
    logic [CHAIN_W-1:0] chain_q;
    logic [CHAIN_W-1:0] hold_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SHIFT_ST;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SHIFT_ST: if (load_lvl)  state_d = XFER_ST;
            XFER_ST:  if (!load_lvl) state_d = SHIFT_ST;
            default:  state_d = SHIFT_ST;
        endcase
    end

    // scan chain: newest bit at position 0
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        chain_q <= '0;
        else if (shift_en) chain_q <= {chain_q[CHAIN_W-2:0], bit_in};
    end

    // outputs: hold register follows the chain in XFER_ST
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= '0;
        else begin
            unique case (state_q)
                XFER_ST:  hold_q <= chain_q;
                SHIFT_ST: hold_q <= hold_q;
                default:  hold_q <= hold_q;
            endcase
        end
    end

    assign chain_end = chain_q[CHAIN_W-1];
    assign hold_o    = hold_q;
endmodule

// File: rtl/dlycode_channel.sv
module dlycode_channel #(
    parameter int CODE_W  = 10,
    parameter int DLY_W   = 13,
    parameter int BASE_PS = 2000,
    parameter int STEP_PS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code,
    input  logic              din,
    input  logic              ena_n,
    output logic [DLY_W-1:0]  dly_ps,
    output logic              q,
    output logic              q_n
);
    localparam logic [DLY_W-1:0] BASE_V = DLY_W'(BASE_PS);
    localparam logic [DLY_W-1:0] STEP_V = DLY_W'(STEP_PS);

    logic [DLY_W-1:0] weighted;

    // sum of binary-weighted steps
    always_comb begin
        weighted = '0;
        for (int i = 0; i < CODE_W; i++) begin
            if (code[i]) weighted = weighted + (STEP_V << i);
        end
        dly_ps = BASE_V + weighted;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q   <= 1'b0;
            q_n <= 1'b1;
        end else if (ena_n) begin
            q   <= 1'b0;
            q_n <= 1'b1;
        end else begin
            q   <= din;
            q_n <= ~din;
        end
    end
endmodule

// File: rtl/dlycode_loader.sv
module dlycode_loader
    import dlycode_pkg::*;
#(
    parameter int CW  = dlycode_pkg::CODE_W,
    parameter int DW  = dlycode_pkg::DLY_W,
    parameter int BPS = dlycode_pkg::BASE_PS,
    parameter int SPS = dlycode_pkg::STEP_PS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ser_din,
    input  logic          ser_clk,
    input  logic          ser_load,
    output logic          ser_dout,
    input  logic          in_a,
    input  logic          ena_n_a,
    input  logic          in_b,
    input  logic          ena_n_b,
    output logic          q_a,
    output logic          q_n_a,
    output logic          q_b,
    output logic          q_n_b,
    output logic [CW-1:0] code_a,
    output logic [CW-1:0] code_b,
    output logic [DW-1:0] dly_a,
    output logic [DW-1:0] dly_b
);
    localparam int TOT_W = CW * NCH;

    logic [2:0]       s_lvl, s_rise;
    logic             load_s, sclk_rise, din_s;
    logic [TOT_W-1:0] hold;

    dlycode_sync #(.WIDTH(3), .STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .async_i({ser_load, ser_clk, ser_din}),
        .sync_o(s_lvl), .rise_o(s_rise)
    );

    assign din_s     = s_lvl[0];
    assign sclk_rise = s_rise[1];
    assign load_s    = s_lvl[2];

    dlycode_chain #(.CHAIN_W(TOT_W)) u_chain (
        .clk(clk), .rst_n(rst_n),
        .shift_en(sclk_rise), .bit_in(din_s), .load_lvl(load_s),
        .chain_end(ser_dout), .hold_o(hold)
    );

    logic [CW-1:0] codes  [NCH];
    logic          dins   [NCH];
    logic          enas   [NCH];
    logic [DW-1:0] dlys   [NCH];
    logic          qs     [NCH];
    logic          qns    [NCH];

    assign dins[0] = in_a;  assign enas[0] = ena_n_a;
    assign dins[1] = in_b;  assign enas[1] = ena_n_b;

    genvar c;
    generate
        for (c = 0; c < NCH; c++) begin : g_ch
            assign codes[c] = hold[c*CW +: CW];
            dlycode_channel #(.CODE_W(CW), .DLY_W(DW), .BASE_PS(BPS), .STEP_PS(SPS)) u_ch (
                .clk(clk), .rst_n(rst_n), .code(codes[c]),
                .din(dins[c]), .ena_n(enas[c]),
                .dly_ps(dlys[c]), .q(qs[c]), .q_n(qns[c])
            );
        end
    endgenerate

    assign code_a = codes[0];
    assign code_b = codes[1];
    assign dly_a  = dlys[0];
    assign dly_b  = dlys[1];
    assign q_a    = qs[0];
    assign q_n_a  = qns[0];
    assign q_b    = qs[1];
    assign q_n_b  = qns[1];
endmodule

// File: rtl/dlycode_loader_chk.sv
module dlycode_loader_chk #(
    parameter int CW = 10,
    parameter int DW = 13
) (
    input logic          clk,
    input logic          rst_n,
    input logic          load_s,
    input logic          sclk_rise,
    input logic          ser_dout,
    input logic          ena_n_a,
    input logic          ena_n_b,
    input logic          q_a,
    input logic          q_n_a,
    input logic          q_b,
    input logic          q_n_b,
    input logic [CW-1:0] code_a,
    input logic [CW-1:0] code_b,
    input logic [DW-1:0] dly_a,
    input logic [DW-1:0] dly_b
);
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(load_s) |=> $stable({code_b, code_a}));

    assert_dout_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_rise |=> $stable(ser_dout));

    assert_monotone_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (code_a > $past(code_a)) |-> (dly_a > $past(dly_a)));

    assert_gate_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ena_n_a |=> (!q_a && q_n_a));

    assert_gate_b_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ena_n_b |=> (!q_b && q_n_b));

    assert_compl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q_a != q_n_a) && (q_b != q_n_b));
endmodule

bind dlycode_loader dlycode_loader_chk #(.CW(CW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .load_s(load_s), .sclk_rise(sclk_rise),
    .ser_dout(ser_dout), .ena_n_a(ena_n_a), .ena_n_b(ena_n_b),
    .q_a(q_a), .q_n_a(q_n_a), .q_b(q_b), .q_n_b(q_n_b),
    .code_a(code_a), .code_b(code_b), .dly_a(dly_a), .dly_b(dly_b)
);

// File: tb/dlycode_loader_bench.sv
module dlycode_loader_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_din = 1'b0, ser_clk = 1'b0, ser_load = 1'b0;
    logic in_a = 1'b0, ena_n_a = 1'b0, in_b = 1'b0, ena_n_b = 1'b0;
    logic ser_dout, q_a, q_n_a, q_b, q_n_b;
    logic [9:0]  code_a, code_b;
    logic [12:0] dly_a, dly_b;

    int n_chk = 0, n_bad = 0, n_shift = 0;
    logic hist [512];
    logic [19:0] cur_word = '0;

    always #10 clk = ~clk;

    dlycode_loader u_dlycode_loader (
        .clk(clk), .rst_n(rst_n), .ser_din(ser_din), .ser_clk(ser_clk),
        .ser_load(ser_load), .ser_dout(ser_dout), .in_a(in_a), .ena_n_a(ena_n_a),
        .in_b(in_b), .ena_n_b(ena_n_b), .q_a(q_a), .q_n_a(q_n_a), .q_b(q_b),
        .q_n_b(q_n_b), .code_a(code_a), .code_b(code_b), .dly_a(dly_a), .dly_b(dly_b)
    );

    localparam logic [19:0] WORDS [8] = '{
        20'h00000, 20'hFFFFF, 20'h003FF, 20'hFFC00,
        20'hAAAAA, 20'h12345, 20'h80001, 20'h5A3C6
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_dly(input logic [9:0] c);
        int s = 2000;
        for (int i = 0; i < 10; i++) if (c[i]) s += 5 * (1 << i);
        return s;
    endfunction

    task automatic check_codes(input string req, input logic [19:0] w);
        chk({req, " code_a"}, int'(code_a), int'(w[9:0]));
        chk({req, " code_b"}, int'(code_b), int'(w[19:10]));
        chk("R6 dly_a", int'(dly_a), exp_dly(w[9:0]));
        chk("R6 dly_b", int'(dly_b), exp_dly(w[19:10]));
    endtask

    // one shift edge; checks the chain-end output after it (R5)
    task automatic shift_bit(input logic b);
        @(negedge clk) ser_din = b;
        repeat (3) @(negedge clk);
        ser_clk = 1'b1;
        repeat (6) @(negedge clk);
        hist[n_shift] = b;
        chk("R5 ser_dout lag", int'(ser_dout), (n_shift >= 19) ? int'(hist[n_shift-19]) : 0);
        n_shift++;
        ser_clk = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic shift_word(input logic [19:0] w);
        for (int i = 19; i >= 0; i--) shift_bit(w[i]);
    endtask

    task automatic pulse_load();
        @(negedge clk) ser_load = 1'b1;
        repeat (8) @(negedge clk);
        ser_load = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 code_a", int'(code_a), 0);
        chk("R1 code_b", int'(code_b), 0);
        chk("R1 dly_a", int'(dly_a), 2000);
        chk("R1 dout", int'(ser_dout), 0);
        chk("R1 q_a", int'(q_a), 0);
        chk("R1 q_n_b", int'(q_n_b), 1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // table walk: R2, R3, R5, R6
        for (int k = 0; k < 8; k++) begin
            shift_word(WORDS[k]);
            check_codes("R3 held while load low", cur_word);
            pulse_load();
            cur_word = WORDS[k];
            check_codes("R2 after load", cur_word);
        end

        // R4: transparent path, a shift during high load reaches codes
        @(negedge clk) ser_load = 1'b1;
        repeat (8) @(negedge clk);
        @(negedge clk) ser_din = 1'b1;
        repeat (3) @(negedge clk);
        ser_clk = 1'b1;
        repeat (8) @(negedge clk);
        cur_word = {cur_word[18:0], 1'b1};
        check_codes("R4 transparent", cur_word);
        ser_clk = 1'b0;
        repeat (4) @(negedge clk);
        ser_load = 1'b0;
        repeat (8) @(negedge clk);

        // R7 / R8: enable gating
        in_a = 1'b1; in_b = 1'b1; ena_n_a = 1'b0; ena_n_b = 1'b0;
        repeat (2) @(negedge clk);
        chk("R7 q_a pass", int'(q_a), 1);
        chk("R7 q_n_a pass", int'(q_n_a), 0);
        ena_n_a = 1'b1;
        repeat (2) @(negedge clk);
        chk("R7 q_a forced", int'(q_a), 0);
        chk("R7 q_n_a forced", int'(q_n_a), 1);
        chk("R8 q_b unaffected", int'(q_b), 1);
        ena_n_a = 1'b0; ena_n_b = 1'b1; in_a = 1'b0;
        repeat (2) @(negedge clk);
        chk("R8 q_b forced", int'(q_b), 0);
        chk("R8 q_n_b forced", int'(q_n_b), 1);
        chk("R7 q_a follows", int'(q_a), 0);
        chk("R7 q_n_a follows", int'(q_n_a), 1);
        ena_n_b = 1'b0;

        // R1: reset in mid-operation
        in_a = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 code_a after reset", int'(code_a), 0);
        chk("R1 code_b after reset", int'(code_b), 0);
        chk("R1 dly_b after reset", int'(dly_b), 2000);
        chk("R1 dout after reset", int'(ser_dout), 0);
        chk("R1 q_a after reset", int'(q_a), 0);
        chk("R1 q_n_a after reset", int'(q_n_a), 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule